// File: doc/BRIEF.md
# Cache Request Queueing Front-End

This block sits between a group of load/store units and a cache controller that works on one request at a time. The units post memory events of four kinds: load misses, store misses, flushes of dirty lines and evictions of lines being replaced. Each kind goes into its own first-in first-out queue. The oldest entry of every queue is shown to the controller together with a valid flag. The controller takes an entry out with a strobe for that kind, and only after it has finished the request. The units can therefore issue in bursts while the controller drains at its own rate.

Every kind carries its own payload. Loads and stores carry a thread number, a line address and a coherent flag. Flushes carry an address, the full line data, a per-byte dirty mask and a coherent flag. Evictions carry an address, the line data and a coherent flag. When several units post the same kind in one cycle, the queue takes the unit with the lowest index and holds the others off with their accept signals. A queue that is full refuses new posts of its own kind only.

Top module: `cq_frontend`

## Requirements
- R1: The four kinds are kept in independent queues. Posting to, filling or draining one queue never changes the accept signals, head flags or head payload of another queue.
- R2: Each queue delivers its entries at its head in the order in which they were accepted.
- R3: A head entry stays in place and its payload stays unchanged until the controller asserts the dequeue strobe of that kind. A strobe retires exactly one entry at the clock edge where it is seen.
- R4: A head valid flag is 1 exactly when its queue holds at least one entry. After reset all head valid flags and all full flags are 0.
- R5: A load or store head shows the thread number, address and coherent flag that the accepted unit drove in the cycle it was accepted.
- R6: A flush head shows the address, line data, dirty mask and coherent flag of the accepted post. An evict head shows the address, line data and coherent flag.
- R7: Each queue holds DEPTH entries (default 4). Its full flag is 1 exactly when it holds DEPTH entries. While it is full and its dequeue strobe is low, every accept of that kind is 0 in the same cycle.
- R8: In each cycle and for each kind, at most one unit is accepted. It is the lowest-indexed unit whose post valid is 1, provided the queue has room. The accept is combinational, in the same cycle as the post, and the entry is stored at the next clock edge.
- R9: A dequeue strobe on an empty queue is ignored. The queue stays empty, or holds only what was accepted in that cycle, and later entries still come out in order.
- R10: On a full queue, a post in the same cycle as that kind's dequeue strobe is accepted. The queue stays full, and the new entry joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ldPostValid | input | NUM_UNITS | Load post request, one bit per unit |
| ldPostThread | input | NUM_UNITS*THREAD_W | Load thread number, per unit |
| ldPostAddr | input | NUM_UNITS*ADDR_W | Load line address, per unit |
| ldPostCoherent | input | NUM_UNITS | Load coherent flag, per unit |
| ldPostAccept | output | NUM_UNITS | Load post taken this cycle, per unit |
| stPostValid | input | NUM_UNITS | Store post request, per unit |
| stPostThread | input | NUM_UNITS*THREAD_W | Store thread number, per unit |
| stPostAddr | input | NUM_UNITS*ADDR_W | Store line address, per unit |
| stPostCoherent | input | NUM_UNITS | Store coherent flag, per unit |
| stPostAccept | output | NUM_UNITS | Store post taken this cycle, per unit |
| flPostValid | input | NUM_UNITS | Flush post request, per unit |
| flPostAddr | input | NUM_UNITS*ADDR_W | Flush address, per unit |
| flPostLine | input | NUM_UNITS*LINE_BYTES*8 | Flush line data, per unit |
| flPostDirty | input | NUM_UNITS*LINE_BYTES | Flush per-byte dirty mask, per unit |
| flPostCoherent | input | NUM_UNITS | Flush coherent flag, per unit |
| flPostAccept | output | NUM_UNITS | Flush post taken this cycle, per unit |
| evPostValid | input | NUM_UNITS | Evict post request, per unit |
| evPostAddr | input | NUM_UNITS*ADDR_W | Evict address, per unit |
| evPostLine | input | NUM_UNITS*LINE_BYTES*8 | Evict line data, per unit |
| evPostCoherent | input | NUM_UNITS | Evict coherent flag, per unit |
| evPostAccept | output | NUM_UNITS | Evict post taken this cycle, per unit |
| ldFull | output | 1 | Load queue full |
| stFull | output | 1 | Store queue full |
| flFull | output | 1 | Flush queue full |
| evFull | output | 1 | Evict queue full |
| ldHeadValid | output | 1 | Load head present |
| ldHeadThread | output | THREAD_W | Load head thread number |
| ldHeadAddr | output | ADDR_W | Load head address |
| ldHeadCoherent | output | 1 | Load head coherent flag |
| ldDequeue | input | 1 | Retire load head |
| stHeadValid | output | 1 | Store head present |
| stHeadThread | output | THREAD_W | Store head thread number |
| stHeadAddr | output | ADDR_W | Store head address |
| stHeadCoherent | output | 1 | Store head coherent flag |
| stDequeue | input | 1 | Retire store head |
| flHeadValid | output | 1 | Flush head present |
| flHeadAddr | output | ADDR_W | Flush head address |
| flHeadLine | output | LINE_BYTES*8 | Flush head line data |
| flHeadDirty | output | LINE_BYTES | Flush head dirty mask |
| flHeadCoherent | output | 1 | Flush head coherent flag |
| flDequeue | input | 1 | Retire flush head |
| evHeadValid | output | 1 | Evict head present |
| evHeadAddr | output | ADDR_W | Evict head address |
| evHeadLine | output | LINE_BYTES*8 | Evict head line data |
| evHeadCoherent | output | 1 | Evict head coherent flag |
| evDequeue | input | 1 | Retire evict head |

## Verification
The hardest case to reach is a full queue that sees a dequeue strobe and a post from more than one unit in the same cycle. Only the lowest-indexed unit may be accepted, and the occupancy must stay at the limit. Random traffic with a high post rate and a low dequeue rate seldom lines these events up. A directed phase therefore first fills the load queue with dequeues held off, then keeps both units posting while it pulses the strobe. Another directed phase drives the strobe after a queue has drained, to show that a dequeue on an empty queue leaves later ordering intact. Random phases with several post and dequeue rates then cover the interplay between kinds against a queue model in the bench.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int NUM_KINDS = 4;
  localparam int IDX_LOAD  = 0;
  localparam int IDX_STORE = 1;
  localparam int IDX_FLUSH = 2;
  localparam int IDX_EVICT = 3;

  // strobes from control to datapath, one per queue
  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;

  // occupancy state from datapath to control, one per queue
  typedef struct packed {
    logic full;
    logic empty;
  } qStatus_t;
endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPop, doPush;

  assign empty  = (count == '0);
  assign full   = (count == MAX_CNT);
  assign doPop  = pop & ~empty;
  assign doPush = push & (~full | doPop);
  assign rdData = store[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= wrData;
  end
endmodule

// File: rtl/cq_ctrl.sv
module cq_ctrl
  import cq_pkg::*;
#(
  parameter int NUM_UNITS = 2,
  localparam int SEL_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic [NUM_KINDS-1:0][NUM_UNITS-1:0] postValid,
  input  logic [NUM_KINDS-1:0]                dequeue,
  input  qStatus_t [NUM_KINDS-1:0]            status,
  output logic [NUM_KINDS-1:0][NUM_UNITS-1:0] accept,
  output logic [NUM_KINDS-1:0][SEL_W-1:0]     selIdx,
  output qStrobe_t [NUM_KINDS-1:0]            strobes
);
  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    logic found;
    logic room;
    logic [SEL_W-1:0] pick;

    // fixed priority: lowest unit index wins
    always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (!found && postValid[k][u]) begin
          found = 1'b1;
          pick  = SEL_W'(u);
        end
      end
    end

    assign strobes[k].pop  = dequeue[k] & ~status[k].empty;
    assign room            = ~status[k].full | strobes[k].pop;
    assign strobes[k].push = found & room;
    assign selIdx[k]       = pick;

    always_comb begin
      accept[k] = '0;
      if (strobes[k].push) accept[k][pick] = 1'b1;
    end
  end
endmodule

// File: rtl/cq_datapath.sv
module cq_datapath
  import cq_pkg::*;
#(
  parameter int NUM_UNITS  = 2,
  parameter int THREAD_W   = 2,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 8,
  parameter int DEPTH      = 4,
  localparam int SEL_W  = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_UNITS*THREAD_W-1:0]  ldPostThread,
  input  logic [NUM_UNITS*ADDR_W-1:0]    ldPostAddr,
  input  logic [NUM_UNITS-1:0]           ldPostCoherent,
  input  logic [NUM_UNITS*THREAD_W-1:0]  stPostThread,
  input  logic [NUM_UNITS*ADDR_W-1:0]    stPostAddr,
  input  logic [NUM_UNITS-1:0]           stPostCoherent,
  input  logic [NUM_UNITS*ADDR_W-1:0]    flPostAddr,
  input  logic [NUM_UNITS*LINE_W-1:0]    flPostLine,
  input  logic [NUM_UNITS*LINE_BYTES-1:0] flPostDirty,
  input  logic [NUM_UNITS-1:0]           flPostCoherent,
  input  logic [NUM_UNITS*ADDR_W-1:0]    evPostAddr,
  input  logic [NUM_UNITS*LINE_W-1:0]    evPostLine,
  input  logic [NUM_UNITS-1:0]           evPostCoherent,
  input  logic [NUM_KINDS-1:0][SEL_W-1:0] selIdx,
  input  qStrobe_t [NUM_KINDS-1:0]       strobes,
  output qStatus_t [NUM_KINDS-1:0]       status,
  output logic [THREAD_W-1:0]            ldHeadThread,
  output logic [ADDR_W-1:0]              ldHeadAddr,
  output logic                           ldHeadCoherent,
  output logic [THREAD_W-1:0]            stHeadThread,
  output logic [ADDR_W-1:0]              stHeadAddr,
  output logic                           stHeadCoherent,
  output logic [ADDR_W-1:0]              flHeadAddr,
  output logic [LINE_W-1:0]              flHeadLine,
  output logic [LINE_BYTES-1:0]          flHeadDirty,
  output logic                           flHeadCoherent,
  output logic [ADDR_W-1:0]              evHeadAddr,
  output logic [LINE_W-1:0]              evHeadLine,
  output logic                           evHeadCoherent
);
  localparam int LDST_W  = THREAD_W + ADDR_W + 1;
  localparam int FLUSH_W = ADDR_W + LINE_W + LINE_BYTES + 1;
  localparam int EVICT_W = ADDR_W + LINE_W + 1;

  logic [LDST_W-1:0]  ldUnitPk [NUM_UNITS];
  logic [LDST_W-1:0]  stUnitPk [NUM_UNITS];
  logic [FLUSH_W-1:0] flUnitPk [NUM_UNITS];
  logic [EVICT_W-1:0] evUnitPk [NUM_UNITS];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign ldUnitPk[u] = {ldPostCoherent[u], ldPostAddr[u*ADDR_W +: ADDR_W],
                          ldPostThread[u*THREAD_W +: THREAD_W]};
    assign stUnitPk[u] = {stPostCoherent[u], stPostAddr[u*ADDR_W +: ADDR_W],
                          stPostThread[u*THREAD_W +: THREAD_W]};
    assign flUnitPk[u] = {flPostCoherent[u], flPostDirty[u*LINE_BYTES +: LINE_BYTES],
                          flPostLine[u*LINE_W +: LINE_W], flPostAddr[u*ADDR_W +: ADDR_W]};
    assign evUnitPk[u] = {evPostCoherent[u], evPostLine[u*LINE_W +: LINE_W],
                          evPostAddr[u*ADDR_W +: ADDR_W]};
  end

  logic [LDST_W-1:0]  ldHeadPk, stHeadPk;
  logic [FLUSH_W-1:0] flHeadPk;
  logic [EVICT_W-1:0] evHeadPk;

  cq_fifo #(.WIDTH(LDST_W), .DEPTH(DEPTH)) u_ldQ (
    .clk(clk), .rstN(rstN),
    .push(strobes[IDX_LOAD].push), .pop(strobes[IDX_LOAD].pop),
    .wrData(ldUnitPk[selIdx[IDX_LOAD]]), .rdData(ldHeadPk),
    .full(status[IDX_LOAD].full), .empty(status[IDX_LOAD].empty));

  cq_fifo #(.WIDTH(LDST_W), .DEPTH(DEPTH)) u_stQ (
    .clk(clk), .rstN(rstN),
    .push(strobes[IDX_STORE].push), .pop(strobes[IDX_STORE].pop),
    .wrData(stUnitPk[selIdx[IDX_STORE]]), .rdData(stHeadPk),
    .full(status[IDX_STORE].full), .empty(status[IDX_STORE].empty));

  cq_fifo #(.WIDTH(FLUSH_W), .DEPTH(DEPTH)) u_flQ (
    .clk(clk), .rstN(rstN),
    .push(strobes[IDX_FLUSH].push), .pop(strobes[IDX_FLUSH].pop),
    .wrData(flUnitPk[selIdx[IDX_FLUSH]]), .rdData(flHeadPk),
    .full(status[IDX_FLUSH].full), .empty(status[IDX_FLUSH].empty));

  cq_fifo #(.WIDTH(EVICT_W), .DEPTH(DEPTH)) u_evQ (
    .clk(clk), .rstN(rstN),
    .push(strobes[IDX_EVICT].push), .pop(strobes[IDX_EVICT].pop),
    .wrData(evUnitPk[selIdx[IDX_EVICT]]), .rdData(evHeadPk),
    .full(status[IDX_EVICT].full), .empty(status[IDX_EVICT].empty));

  assign {ldHeadCoherent, ldHeadAddr, ldHeadThread} = ldHeadPk;
  assign {stHeadCoherent, stHeadAddr, stHeadThread} = stHeadPk;
  assign {flHeadCoherent, flHeadDirty, flHeadLine, flHeadAddr} = flHeadPk;
  assign {evHeadCoherent, evHeadLine, evHeadAddr} = evHeadPk;
endmodule

// File: rtl/cq_frontend.sv
module cq_frontend
  import cq_pkg::*;
#(
  parameter int NUM_UNITS  = 2,
  parameter int THREAD_W   = 2,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 8,
  parameter int DEPTH      = 4,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_UNITS-1:0]            ldPostValid,
  input  logic [NUM_UNITS*THREAD_W-1:0]   ldPostThread,
  input  logic [NUM_UNITS*ADDR_W-1:0]     ldPostAddr,
  input  logic [NUM_UNITS-1:0]            ldPostCoherent,
  output logic [NUM_UNITS-1:0]            ldPostAccept,
  input  logic [NUM_UNITS-1:0]            stPostValid,
  input  logic [NUM_UNITS*THREAD_W-1:0]   stPostThread,
  input  logic [NUM_UNITS*ADDR_W-1:0]     stPostAddr,
  input  logic [NUM_UNITS-1:0]            stPostCoherent,
  output logic [NUM_UNITS-1:0]            stPostAccept,
  input  logic [NUM_UNITS-1:0]            flPostValid,
  input  logic [NUM_UNITS*ADDR_W-1:0]     flPostAddr,
  input  logic [NUM_UNITS*LINE_W-1:0]     flPostLine,
  input  logic [NUM_UNITS*LINE_BYTES-1:0] flPostDirty,
  input  logic [NUM_UNITS-1:0]            flPostCoherent,
  output logic [NUM_UNITS-1:0]            flPostAccept,
  input  logic [NUM_UNITS-1:0]            evPostValid,
  input  logic [NUM_UNITS*ADDR_W-1:0]     evPostAddr,
  input  logic [NUM_UNITS*LINE_W-1:0]     evPostLine,
  input  logic [NUM_UNITS-1:0]            evPostCoherent,
  output logic [NUM_UNITS-1:0]            evPostAccept,
  output logic                            ldFull,
  output logic                            stFull,
  output logic                            flFull,
  output logic                            evFull,
  output logic                            ldHeadValid,
  output logic [THREAD_W-1:0]             ldHeadThread,
  output logic [ADDR_W-1:0]               ldHeadAddr,
  output logic                            ldHeadCoherent,
  input  logic                            ldDequeue,
  output logic                            stHeadValid,
  output logic [THREAD_W-1:0]             stHeadThread,
  output logic [ADDR_W-1:0]               stHeadAddr,
  output logic                            stHeadCoherent,
  input  logic                            stDequeue,
  output logic                            flHeadValid,
  output logic [ADDR_W-1:0]               flHeadAddr,
  output logic [LINE_W-1:0]               flHeadLine,
  output logic [LINE_BYTES-1:0]           flHeadDirty,
  output logic                            flHeadCoherent,
  input  logic                            flDequeue,
  output logic                            evHeadValid,
  output logic [ADDR_W-1:0]               evHeadAddr,
  output logic [LINE_W-1:0]               evHeadLine,
  output logic                            evHeadCoherent,
  input  logic                            evDequeue
);
  localparam int SEL_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

  logic [NUM_KINDS-1:0][NUM_UNITS-1:0] postValid, accept;
  logic [NUM_KINDS-1:0][SEL_W-1:0]     selIdx;
  logic [NUM_KINDS-1:0]                dequeue;
  qStrobe_t [NUM_KINDS-1:0]            strobes;
  qStatus_t [NUM_KINDS-1:0]            status;

  assign postValid[IDX_LOAD]  = ldPostValid;
  assign postValid[IDX_STORE] = stPostValid;
  assign postValid[IDX_FLUSH] = flPostValid;
  assign postValid[IDX_EVICT] = evPostValid;
  assign dequeue = {evDequeue, flDequeue, stDequeue, ldDequeue};

  cq_ctrl #(.NUM_UNITS(NUM_UNITS)) u_ctrl (
    .postValid(postValid), .dequeue(dequeue), .status(status),
    .accept(accept), .selIdx(selIdx), .strobes(strobes));

  cq_datapath #(
    .NUM_UNITS(NUM_UNITS), .THREAD_W(THREAD_W), .ADDR_W(ADDR_W),
    .LINE_BYTES(LINE_BYTES), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .ldPostThread(ldPostThread), .ldPostAddr(ldPostAddr), .ldPostCoherent(ldPostCoherent),
    .stPostThread(stPostThread), .stPostAddr(stPostAddr), .stPostCoherent(stPostCoherent),
    .flPostAddr(flPostAddr), .flPostLine(flPostLine), .flPostDirty(flPostDirty),
    .flPostCoherent(flPostCoherent),
    .evPostAddr(evPostAddr), .evPostLine(evPostLine), .evPostCoherent(evPostCoherent),
    .selIdx(selIdx), .strobes(strobes), .status(status),
    .ldHeadThread(ldHeadThread), .ldHeadAddr(ldHeadAddr), .ldHeadCoherent(ldHeadCoherent),
    .stHeadThread(stHeadThread), .stHeadAddr(stHeadAddr), .stHeadCoherent(stHeadCoherent),
    .flHeadAddr(flHeadAddr), .flHeadLine(flHeadLine), .flHeadDirty(flHeadDirty),
    .flHeadCoherent(flHeadCoherent),
    .evHeadAddr(evHeadAddr), .evHeadLine(evHeadLine), .evHeadCoherent(evHeadCoherent));

  assign ldPostAccept = accept[IDX_LOAD];
  assign stPostAccept = accept[IDX_STORE];
  assign flPostAccept = accept[IDX_FLUSH];
  assign evPostAccept = accept[IDX_EVICT];

  assign ldFull = status[IDX_LOAD].full;
  assign stFull = status[IDX_STORE].full;
  assign flFull = status[IDX_FLUSH].full;
  assign evFull = status[IDX_EVICT].full;

  assign ldHeadValid = ~status[IDX_LOAD].empty;
  assign stHeadValid = ~status[IDX_STORE].empty;
  assign flHeadValid = ~status[IDX_FLUSH].empty;
  assign evHeadValid = ~status[IDX_EVICT].empty;
endmodule

// File: rtl/cq_frontend_chk.sv
module cq_frontend_chk #(
  parameter int NUM_UNITS  = 2,
  parameter int THREAD_W   = 2,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_UNITS-1:0]    ldPostValid,
  input logic [NUM_UNITS-1:0]    ldPostAccept,
  input logic                    ldFull,
  input logic                    ldHeadValid,
  input logic [THREAD_W-1:0]     ldHeadThread,
  input logic [ADDR_W-1:0]       ldHeadAddr,
  input logic                    ldDequeue,
  input logic [NUM_UNITS-1:0]    evPostAccept,
  input logic                    flFull,
  input logic                    flHeadValid,
  input logic [LINE_BYTES*8-1:0] flHeadLine,
  input logic                    flDequeue
);
  assert_ld_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ldPostAccept));
  assert_ev_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(evPostAccept));
  assert_ld_accept_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ldPostAccept & ~ldPostValid) == '0);
  assert_ld_priority_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ldPostValid[0] && !ldFull) |-> ldPostAccept[0]);
  assert_ld_full_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ldFull && !ldDequeue) |-> (ldPostAccept == '0));
  assert_ld_head_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ldHeadValid && !ldDequeue) |=> (ldHeadValid && $stable(ldHeadAddr) && $stable(ldHeadThread)));
  assert_fl_head_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (flHeadValid && !flDequeue) |=> (flHeadValid && $stable(flHeadLine)));
  assert_ld_empty_deq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ldHeadValid && ldDequeue && ldPostAccept == '0) |=> !ldHeadValid);
  assert_ld_full_swap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ldFull && ldDequeue && (|ldPostAccept)) |=> ldFull);
  assert_fl_full_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    flFull |-> flHeadValid);
endmodule

bind cq_frontend cq_frontend_chk #(
  .NUM_UNITS(NUM_UNITS), .THREAD_W(THREAD_W), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN),
  .ldPostValid(ldPostValid), .ldPostAccept(ldPostAccept), .ldFull(ldFull),
  .ldHeadValid(ldHeadValid), .ldHeadThread(ldHeadThread), .ldHeadAddr(ldHeadAddr),
  .ldDequeue(ldDequeue), .evPostAccept(evPostAccept), .flFull(flFull),
  .flHeadValid(flHeadValid), .flHeadLine(flHeadLine), .flDequeue(flDequeue));

// File: tb/tb_cq_frontend.sv
`timescale 1ns/1ps
module tb_cq_frontend;
  localparam int NU = 2;
  localparam int TW = 2;
  localparam int AW = 32;
  localparam int LB = 8;
  localparam int LW = LB * 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [NU-1:0] ldPostValid, stPostValid, flPostValid, evPostValid;
  logic [NU-1:0] ldPostAccept, stPostAccept, flPostAccept, evPostAccept;
  logic [NU*TW-1:0] ldPostThread, stPostThread;
  logic [NU*AW-1:0] ldPostAddr, stPostAddr, flPostAddr, evPostAddr;
  logic [NU-1:0] ldPostCoherent, stPostCoherent, flPostCoherent, evPostCoherent;
  logic [NU*LW-1:0] flPostLine, evPostLine;
  logic [NU*LB-1:0] flPostDirty;
  logic ldFull, stFull, flFull, evFull;
  logic ldHeadValid, stHeadValid, flHeadValid, evHeadValid;
  logic [TW-1:0] ldHeadThread, stHeadThread;
  logic [AW-1:0] ldHeadAddr, stHeadAddr, flHeadAddr, evHeadAddr;
  logic ldHeadCoherent, stHeadCoherent, flHeadCoherent, evHeadCoherent;
  logic [LW-1:0] flHeadLine, evHeadLine;
  logic [LB-1:0] flHeadDirty;
  logic ldDequeue, stDequeue, flDequeue, evDequeue;

  // bench-side stimulus, one payload vector per kind and unit
  logic [127:0] pl [4][NU];
  logic [NU-1:0] pv [4];
  logic [3:0] deq;

  assign ldPostValid = pv[0];
  assign stPostValid = pv[1];
  assign flPostValid = pv[2];
  assign evPostValid = pv[3];
  assign {evDequeue, flDequeue, stDequeue, ldDequeue} = deq;

  for (genvar u = 0; u < NU; u++) begin : g_drv
    assign ldPostThread[u*TW +: TW] = pl[0][u][1:0];
    assign ldPostAddr[u*AW +: AW]   = pl[0][u][33:2];
    assign ldPostCoherent[u]        = pl[0][u][34];
    assign stPostThread[u*TW +: TW] = pl[1][u][1:0];
    assign stPostAddr[u*AW +: AW]   = pl[1][u][33:2];
    assign stPostCoherent[u]        = pl[1][u][34];
    assign flPostAddr[u*AW +: AW]   = pl[2][u][31:0];
    assign flPostLine[u*LW +: LW]   = pl[2][u][95:32];
    assign flPostDirty[u*LB +: LB]  = pl[2][u][103:96];
    assign flPostCoherent[u]        = pl[2][u][104];
    assign evPostAddr[u*AW +: AW]   = pl[3][u][31:0];
    assign evPostLine[u*LW +: LW]   = pl[3][u][95:32];
    assign evPostCoherent[u]        = pl[3][u][96];
  end

  logic [127:0] hp [4];
  logic hv [4];
  logic fullV [4];
  logic [NU-1:0] acc [4];
  assign hp[0] = 128'({ldHeadCoherent, ldHeadAddr, ldHeadThread});
  assign hp[1] = 128'({stHeadCoherent, stHeadAddr, stHeadThread});
  assign hp[2] = 128'({flHeadCoherent, flHeadDirty, flHeadLine, flHeadAddr});
  assign hp[3] = 128'({evHeadCoherent, evHeadLine, evHeadAddr});
  assign hv[0] = ldHeadValid;  assign hv[1] = stHeadValid;
  assign hv[2] = flHeadValid;  assign hv[3] = evHeadValid;
  assign fullV[0] = ldFull;    assign fullV[1] = stFull;
  assign fullV[2] = flFull;    assign fullV[3] = evFull;
  assign acc[0] = ldPostAccept; assign acc[1] = stPostAccept;
  assign acc[2] = flPostAccept; assign acc[3] = evPostAccept;

  cq_frontend #(.NUM_UNITS(NU), .THREAD_W(TW), .ADDR_W(AW), .LINE_BYTES(LB), .DEPTH(DEPTH)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [127:0] mq [4][$];

  function automatic logic [127:0] kindMask(int k);
    int w;
    w = (k < 2) ? 35 : ((k == 2) ? 105 : 97);
    return (128'd1 << w) - 128'd1;
  endfunction

  function automatic logic [NU-1:0] expAccept(int k, logic [NU-1:0] v, int size, logic d);
    logic room;
    logic [NU-1:0] r;
    room = (size < DEPTH) || (d && size > 0);
    r = '0;
    if (room) begin
      for (int u = NU - 1; u >= 0; u--) if (v[u]) r = NU'(1) << u;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compare outputs with the model, then advance the model across the coming edge
  task automatic cycle(string req);
    logic [NU-1:0] ea;
    #1;
    for (int k = 0; k < 4; k++) begin
      int sz;
      sz = mq[k].size();
      check(hv[k] == (sz > 0), req, $sformatf("R4 headValid kind%0d", k), 128'(hv[k]), 128'(sz > 0));
      if (sz > 0)
        check(hp[k] == mq[k][0], req, (k < 2) ? $sformatf("R2 R5 head kind%0d", k) :
              $sformatf("R2 R6 head kind%0d", k), hp[k], mq[k][0]);
      check(fullV[k] == (sz == DEPTH), req, $sformatf("R7 full kind%0d", k),
            128'(fullV[k]), 128'(sz == DEPTH));
      ea = expAccept(k, pv[k], sz, deq[k]);
      check(acc[k] == ea, req, $sformatf("R8 accept kind%0d", k), 128'(acc[k]), 128'(ea));
      if (deq[k] && sz > 0) void'(mq[k].pop_front());
      for (int u = 0; u < NU; u++) if (ea[u]) mq[k].push_back(pl[k][u] & kindMask(k));
    end
    @(negedge clk);
  endtask

  task automatic randPayload();
    for (int k = 0; k < 4; k++)
      for (int u = 0; u < NU; u++)
        pl[k][u] = {$urandom, $urandom, $urandom, $urandom} & kindMask(k);
  endtask

  task automatic setAll(logic [NU-1:0] v, logic [3:0] d);
    for (int k = 0; k < 4; k++) pv[k] = v;
    deq = d;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    setAll('0, 4'b0000);
    randPayload();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R4: reset state, everything empty
    cycle("R4");

    // R8: every unit posts every kind, lowest index wins each cycle
    randPayload();
    setAll('1, 4'b0000);
    cycle("R8");
    randPayload();
    pv[0] = 2'b10; pv[1] = 2'b11; pv[2] = 2'b00; pv[3] = 2'b10;
    cycle("R8");

    // R7 / R1: fill the load queue only, then store still accepts
    setAll('0, 4'b0000);
    for (int i = 0; i < 6; i++) begin
      randPayload();
      pv[0] = 2'b11;
      cycle("R7");
    end
    randPayload();
    pv[0] = 2'b11; pv[1] = 2'b01;
    cycle("R1");

    // R10: full load queue, dequeue and post together
    for (int i = 0; i < 3; i++) begin
      randPayload();
      setAll('0, 4'b0001);
      pv[0] = 2'b11;
      cycle("R10");
    end

    // R3: no strobes, heads must not move
    setAll('0, 4'b0000);
    repeat (3) cycle("R3");

    // R9: drain everything and keep strobing empty queues
    setAll('0, 4'b1111);
    repeat (8) cycle("R9");
    randPayload();
    pv[1] = 2'b10;
    cycle("R9");
    setAll('0, 4'b0000);
    pv[2] = 2'b01;
    randPayload();
    cycle("R9");
    setAll('0, 4'b0100);
    cycle("R9");
    setAll('0, 4'b0000);
    cycle("R2");

    // random traffic at several post and dequeue rates
    for (int phase = 0; phase < 3; phase++) begin
      for (int i = 0; i < 1500; i++) begin
        randPayload();
        for (int k = 0; k < 4; k++) begin
          for (int u = 0; u < NU; u++)
            pv[k][u] = ($urandom_range(99) < (phase == 0 ? 70 : (phase == 1 ? 30 : 50)));
          deq[k] = ($urandom_range(99) < (phase == 0 ? 25 : (phase == 1 ? 70 : 50)));
        end
        cycle("R1 R2");
      end
    end

    setAll('0, 4'b0000);
    cycle("R4");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule